// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block handles even parity for a 32-bit multiplexed address/data bus and its 4-bit command/byte-enable lines. Every clock on which the phase-valid strobe is high is an address or data phase. The block registers that phase's bus contents and, on the next clock, works out the parity bit that makes the total number of ones across all 36 bits plus the parity bit even.

When the bridge is driving the bus, that bit is put out one clock after the data it covers, together with an output-enable. When the bridge is receiving, the bit is compared with the incoming parity line in that same lagged clock. A mismatch raises the parity-error output one clock later, provided the parity-error-response enable is set. A mismatch also raises a sticky status bit, whatever the enables are.

A one-clock system-error pulse is raised for a local mismatch when the system-error enable is set. It is also raised for a newly reported downstream error when both the system-error enable and the forward enable are set.

The phase tracker is a three-state machine:
- PH_IDLE: no phase on the previous clock.
- PH_DRIVE: the previous clock was a driven phase.
- PH_RECV: the previous clock was a received phase.

Its transitions are taken on every clock and depend only on the inputs:
- phase-valid low leads to PH_IDLE.
- phase-valid high with the drive flag set leads to PH_DRIVE.
- phase-valid high with the drive flag clear leads to PH_RECV.

Top module: `bus_parity_unit`

## Requirements
- R1: In the clock after a phase with `phase_vld_i`=1 and `drive_i`=1, `par_oe_o` is 1 and `par_o` is 1 exactly when the 36 bits `{ad_i, cbe_i}` of that phase hold an odd number of ones (even parity).
- R2: In a clock that does not follow a driven phase, `par_oe_o` is 0 and `par_o` is 0.
- R3: For a received phase (`phase_vld_i`=1, `drive_i`=0), `par_i` is sampled on the following clock. If it differs from the even-parity bit of that phase and `perr_en_i` is 1 in that sampling clock, `perr_o` is 1 for exactly one clock, two clocks after the phase. Back-to-back bad phases give back-to-back error clocks.
- R4: With `perr_en_i`=0 in the sampling clock, a mismatch leaves `perr_o` at 0.
- R5: No compare is made after a driven phase or after a clock with `phase_vld_i`=0, whatever `par_i` is.
- R6: `perr_sts_o` becomes 1 on any mismatch regardless of the enables and stays 1 until a clock with `sts_clr_i`=1. A mismatch in the same clock as a clear wins.
- R7: A mismatch with `serr_en_i`=1 in the sampling clock gives a one-clock `serr_o` pulse in the same clock as `perr_o` would rise. With `serr_en_i`=0 there is no pulse.
- R8: A rising edge of `ds_serr_i` with `serr_en_i`=1 and `fwd_en_i`=1 gives a one-clock `serr_o` pulse on the next clock. Holding `ds_serr_i` high gives no further pulses, and with `fwd_en_i`=0 there is no pulse.
- R9: A local mismatch and a downstream rising edge in the same clock give a single one-clock `serr_o` pulse.
- R10: During and directly after reset, `par_o`, `par_oe_o`, `perr_o`, `serr_o` and `perr_sts_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ad_i | input | 32 | Address/data bus contents |
| cbe_i | input | 4 | Command/byte-enable bus contents |
| par_i | input | 1 | Incoming parity line |
| phase_vld_i | input | 1 | High on an address or data phase |
| drive_i | input | 1 | 1: bridge drives this phase, 0: bridge receives |
| perr_en_i | input | 1 | Parity-error response enable |
| serr_en_i | input | 1 | System-error enable |
| fwd_en_i | input | 1 | Forward downstream system errors enable |
| ds_serr_i | input | 1 | Downstream system-error strobe |
| sts_clr_i | input | 1 | Write-one-to-clear for the sticky status |
| par_o | output | 1 | Generated parity bit |
| par_oe_o | output | 1 | Parity output enable |
| perr_o | output | 1 | Parity-error indication |
| serr_o | output | 1 | System-error pulse |
| perr_sts_o | output | 1 | Sticky detected-parity-error status |

## Verification
The assertions assume a synchronous, glitch-free environment:
- All inputs change only between clock edges.
- `par_i` belonging to a received phase is presented in the clock right after that phase.
- Enables are sampled in the clock in which they matter.

The stimulus keeps within these assumptions by driving every input on the falling edge and sampling outputs on the falling edge. Each received phase is followed by its parity value in the next clock, and the enables are set before the sampling clock.

Downstream errors are given both as held levels and as single-clock strobes, so that the edge rule is exercised.

// File: rtl/bpar_pkg.sv
package bpar_pkg;

    localparam int unsigned AD_W_DEF  = 32;
    localparam int unsigned CBE_W_DEF = 4;
    localparam int unsigned GRP_DEF   = 8;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_DRIVE = 2'd1,
        PH_RECV  = 2'd2
    } phase_e;

endpackage

// File: rtl/bpar_tree.sv
module bpar_tree #(
    parameter int unsigned W   = 36,
    parameter int unsigned GRP = 8
) (
    input  logic [W-1:0] bits_i,
    output logic         odd_o
);
    localparam int unsigned NG  = (W + GRP - 1) / GRP;
    localparam int unsigned PADW = NG * GRP;

    logic [PADW-1:0] padded;
    logic [NG-1:0]   part;

    always_comb begin
        padded         = '0;
        padded[W-1:0]  = bits_i;
    end

    // first level: one XOR reduction per group of GRP bits
    for (genvar g = 0; g < NG; g++) begin : g_grp
        assign part[g] = ^padded[g*GRP +: GRP];
    end

    assign odd_o = ^part;

endmodule

// File: rtl/bpar_phase_fsm.sv
module bpar_phase_fsm #(
    parameter int unsigned BW = 36
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          phase_vld_i,
    input  logic          drive_i,
    input  logic [BW-1:0] bus_i,
    output logic [BW-1:0] cap_o,
    output logic          drive_slot_o,
    output logic          recv_slot_o
);
    import bpar_pkg::*;

    phase_e state_q, state_d;

    // next state: purely a function of the current phase strobe
    always_comb begin
        if (!phase_vld_i)
            state_d = PH_IDLE;
        else if (drive_i)
            state_d = PH_DRIVE;
        else
            state_d = PH_RECV;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= PH_IDLE;
        else
            state_q <= state_d;
    end

    // captured bus copy for the lagged parity slot
    always_ff @(posedge clk) begin
        if (!rst_n)
            cap_o <= '0;
        else if (phase_vld_i)
            cap_o <= bus_i;
    end

    // outputs decoded from state
    always_comb begin
        drive_slot_o = 1'b0;
        recv_slot_o  = 1'b0;
        unique case (state_q)
            PH_IDLE:  ;
            PH_DRIVE: drive_slot_o = 1'b1;
            PH_RECV:  recv_slot_o  = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/bpar_err.sv
module bpar_err (
    input  logic clk,
    input  logic rst_n,
    input  logic mismatch_i,
    input  logic perr_en_i,
    input  logic serr_en_i,
    input  logic fwd_en_i,
    input  logic ds_serr_i,
    input  logic sts_clr_i,
    output logic perr_o,
    output logic serr_o,
    output logic sts_o
);
    logic ds_q;
    logic ds_new;
    logic local_ev;
    logic fwd_ev;

    assign ds_new   = ds_serr_i & ~ds_q;
    assign local_ev = mismatch_i & serr_en_i;
    assign fwd_ev   = ds_new & serr_en_i & fwd_en_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ds_q   <= 1'b0;
            perr_o <= 1'b0;
            serr_o <= 1'b0;
            sts_o  <= 1'b0;
        end else begin
            ds_q   <= ds_serr_i;
            perr_o <= mismatch_i & perr_en_i;
            serr_o <= local_ev | fwd_ev;
            if (mismatch_i)
                sts_o <= 1'b1;
            else if (sts_clr_i)
                sts_o <= 1'b0;
        end
    end

endmodule

// File: rtl/bus_parity_unit.sv
module bus_parity_unit #(
    parameter int unsigned AD_W  = bpar_pkg::AD_W_DEF,
    parameter int unsigned CBE_W = bpar_pkg::CBE_W_DEF,
    parameter int unsigned GRP   = bpar_pkg::GRP_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AD_W-1:0]  ad_i,
    input  logic [CBE_W-1:0] cbe_i,
    input  logic             par_i,
    input  logic             phase_vld_i,
    input  logic             drive_i,
    input  logic             perr_en_i,
    input  logic             serr_en_i,
    input  logic             fwd_en_i,
    input  logic             ds_serr_i,
    input  logic             sts_clr_i,
    output logic             par_o,
    output logic             par_oe_o,
    output logic             perr_o,
    output logic             serr_o,
    output logic             perr_sts_o
);
    localparam int unsigned BW = AD_W + CBE_W;

    logic [BW-1:0] cap;
    logic          drive_slot;
    logic          recv_slot;
    logic          gen_par;
    logic          mismatch;

    bpar_phase_fsm #(.BW(BW)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .phase_vld_i  (phase_vld_i),
        .drive_i      (drive_i),
        .bus_i        ({ad_i, cbe_i}),
        .cap_o        (cap),
        .drive_slot_o (drive_slot),
        .recv_slot_o  (recv_slot)
    );

    bpar_tree #(.W(BW), .GRP(GRP)) u_tree (
        .bits_i (cap),
        .odd_o  (gen_par)
    );

    assign par_oe_o = drive_slot;
    assign par_o    = drive_slot & gen_par;
    assign mismatch = recv_slot & (gen_par ^ par_i);

    bpar_err u_err (
        .clk        (clk),
        .rst_n      (rst_n),
        .mismatch_i (mismatch),
        .perr_en_i  (perr_en_i),
        .serr_en_i  (serr_en_i),
        .fwd_en_i   (fwd_en_i),
        .ds_serr_i  (ds_serr_i),
        .sts_clr_i  (sts_clr_i),
        .perr_o     (perr_o),
        .serr_o     (serr_o),
        .sts_o      (perr_sts_o)
    );

endmodule

// File: rtl/bpar_chk.sv
module bpar_chk (
    input logic clk,
    input logic rst_n,
    input logic phase_vld_i,
    input logic drive_i,
    input logic perr_en_i,
    input logic serr_en_i,
    input logic par_oe_o,
    input logic perr_o,
    input logic serr_o,
    input logic perr_sts_o
);
    // R1/R2: output enable only in the slot after a driven phase
    p_oe_slot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        par_oe_o |-> $past(phase_vld_i && drive_i));

    // R3/R5: an error indication traces back to a received phase two clocks earlier
    p_perr_origin_r3: assert property (@(posedge clk) disable iff (!rst_n)
        perr_o |-> $past(phase_vld_i && !drive_i, 2));

    // R4: parity error needs the response enable in the sampling clock
    p_perr_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        perr_o |-> $past(perr_en_i));

    // R6: a reported error always leaves the sticky status set
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        perr_o |-> perr_sts_o);

    // R7/R8: no system-error pulse without its enable
    p_serr_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        serr_o |-> $past(serr_en_i));

endmodule

bind bus_parity_unit bpar_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .phase_vld_i (phase_vld_i),
    .drive_i     (drive_i),
    .perr_en_i   (perr_en_i),
    .serr_en_i   (serr_en_i),
    .par_oe_o    (par_oe_o),
    .perr_o      (perr_o),
    .serr_o      (serr_o),
    .perr_sts_o  (perr_sts_o)
);

// File: tb/bus_parity_unit_tb_top.sv
`timescale 1ns/1ps
module bus_parity_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] ad_i;
    logic [3:0]  cbe_i;
    logic        par_i, phase_vld_i, drive_i;
    logic        perr_en_i, serr_en_i, fwd_en_i, ds_serr_i, sts_clr_i;
    logic        par_o, par_oe_o, perr_o, serr_o, perr_sts_o;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    always #2 clk = ~clk;

    bus_parity_unit dut_i (
        .clk(clk), .rst_n(rst_n), .ad_i(ad_i), .cbe_i(cbe_i), .par_i(par_i),
        .phase_vld_i(phase_vld_i), .drive_i(drive_i), .perr_en_i(perr_en_i),
        .serr_en_i(serr_en_i), .fwd_en_i(fwd_en_i), .ds_serr_i(ds_serr_i),
        .sts_clr_i(sts_clr_i), .par_o(par_o), .par_oe_o(par_oe_o),
        .perr_o(perr_o), .serr_o(serr_o), .perr_sts_o(perr_sts_o)
    );

    // {ad[31:0], cbe[3:0], flags[3:0]}; flags = {drive, bad parity, perr_en, serr_en}
    localparam logic [39:0] VECS [0:7] = '{
        {32'h00000000, 4'h0, 4'h8},
        {32'hFFFFFFFF, 4'hE, 4'h8},
        {32'h00000001, 4'h0, 4'h3},
        {32'h12345678, 4'h5, 4'h7},
        {32'hA5A5A5A5, 4'h3, 4'h5},
        {32'hDEADBEEF, 4'h9, 4'h6},
        {32'h80000000, 4'h8, 4'hF},
        {32'h0F0F0F0F, 4'h1, 4'h3}
    };

    task automatic chk(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic even_bit(input logic [35:0] b);
        return ($countones(b) % 2) == 1;
    endfunction

    task automatic clear_sticky();
        @(negedge clk) sts_clr_i = 1'b1;
        @(negedge clk) sts_clr_i = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 0; ad_i = '0; cbe_i = '0; par_i = 0; phase_vld_i = 0; drive_i = 0;
        perr_en_i = 0; serr_en_i = 0; fwd_en_i = 0; ds_serr_i = 0; sts_clr_i = 0;
        repeat (3) @(negedge clk);
        chk("R10 par_o", par_o, 1'b0);
        chk("R10 par_oe_o", par_oe_o, 1'b0);
        chk("R10 perr_o", perr_o, 1'b0);
        chk("R10 serr_o", serr_o, 1'b0);
        chk("R10 perr_sts_o", perr_sts_o, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 par_oe_o after reset", par_oe_o, 1'b0);

        // table walk
        for (int i = 0; i < 8; i++) begin
            logic [39:0] v;
            logic drv, bad, pe, se, ep;
            v   = VECS[i];
            drv = v[3]; bad = v[2]; pe = v[1]; se = v[0];
            ep  = even_bit(v[39:4]);
            @(negedge clk);
            ad_i = v[39:8]; cbe_i = v[7:4]; drive_i = drv; phase_vld_i = 1'b1;
            perr_en_i = pe; serr_en_i = se; par_i = 1'b0;
            @(negedge clk);
            chk("R1 par_oe_o", par_oe_o, drv);
            chk(drv ? "R1 par_o" : "R2 par_o", par_o, drv & ep);
            phase_vld_i = 1'b0;
            par_i = drv ? ~ep : (ep ^ bad);   // a driven phase gets a wrong par_i: R5
            @(negedge clk);
            chk(drv ? "R5 perr_o" : (pe ? "R3 perr_o" : "R4 perr_o"), perr_o, ~drv & bad & pe);
            chk("R7 serr_o", serr_o, ~drv & bad & se);
            chk("R6 perr_sts_o", perr_sts_o, ~drv & bad);
            chk("R2 par_oe_o idle", par_oe_o, 1'b0);
            sts_clr_i = 1'b1;
            @(negedge clk);
            sts_clr_i = 1'b0;
            chk("R3 perr_o single clock", perr_o, 1'b0);
            chk("R6 cleared", perr_sts_o, 1'b0);
        end

        // R5: idle clocks with arbitrary par_i make no check
        perr_en_i = 1; serr_en_i = 1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk) par_i = k[0];
        end
        @(negedge clk);
        chk("R5 idle perr_o", perr_o, 1'b0);
        chk("R5 idle sticky", perr_sts_o, 1'b0);

        // R8: held downstream error gives one pulse
        fwd_en_i = 1;
        @(negedge clk) ds_serr_i = 1'b1;
        @(negedge clk) chk("R8 ds pulse", serr_o, 1'b1);
        @(negedge clk) chk("R8 ds held no repeat", serr_o, 1'b0);
        @(negedge clk) chk("R8 ds held no repeat 2", serr_o, 1'b0);
        ds_serr_i = 1'b0;
        // R8: forward disabled
        @(negedge clk) fwd_en_i = 1'b0; ds_serr_i = 1'b1;
        @(negedge clk) ds_serr_i = 1'b0;
        chk("R8 fwd off", serr_o, 1'b0);
        @(negedge clk) chk("R8 fwd off later", serr_o, 1'b0);

        // R9: local and downstream in the same clock
        fwd_en_i = 1'b1;
        @(negedge clk);
        ad_i = '0; cbe_i = '0; drive_i = 0; phase_vld_i = 1;
        @(negedge clk);
        phase_vld_i = 0; par_i = 1'b1; ds_serr_i = 1'b1;
        @(negedge clk);
        chk("R9 serr_o pulse", serr_o, 1'b1);
        chk("R3 perr_o with zero bus", perr_o, 1'b1);
        ds_serr_i = 1'b0;
        @(negedge clk);
        chk("R9 single pulse", serr_o, 1'b0);
        clear_sticky();

        // R6: set wins over a clear in the same clock
        @(negedge clk);
        ad_i = 32'h3; cbe_i = 4'h0; phase_vld_i = 1;
        @(negedge clk);
        phase_vld_i = 0; par_i = 1'b1; sts_clr_i = 1'b1;
        @(negedge clk);
        chk("R6 set beats clear", perr_sts_o, 1'b1);
        @(negedge clk);
        chk("R6 clear after", perr_sts_o, 1'b0);
        sts_clr_i = 1'b0;

        // R3: back-to-back received phases, first bad, second good
        @(negedge clk);
        ad_i = 32'h0; cbe_i = 4'h1; phase_vld_i = 1;          // parity bit 1
        @(negedge clk);
        ad_i = 32'h7; cbe_i = 4'h0; par_i = 1'b0;             // par_i for phase 1: bad; phase 2 parity 1
        @(negedge clk);
        phase_vld_i = 0; par_i = 1'b1;                         // good for phase 2
        chk("R3 first bad phase", perr_o, 1'b1);
        @(negedge clk);
        chk("R3 second good phase", perr_o, 1'b0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule